// File: doc/BRIEF.md
# Mesh Hop Legality Checker

This block sits at the input of a router in a two-dimensional mesh. Whenever a packet header arrives, it judges the hop that delivered it. The judgement is about the decision the upstream router made, not about where the local router will send the packet next. The upstream router's position follows from the local coordinates and the input port the header came in on. From that position the block works out where a dimension-ordered policy would have sent the packet. That policy resolves the horizontal axis first, then the vertical axis, and ejects the packet when both axes match.

If the actual hop matches that choice, the hop is correct. If it does not match, the block looks up the router the policy would have used in a one-bit-per-node availability map. When that router is marked unavailable, the detour is treated as a legitimate bypass. Otherwise the hop is reported as a routing error, and a sticky flag latches until it is cleared.

The classification is a single layer of combinational logic feeding one output register. It can therefore run beside the header's error-correction decode without adding a cycle to the packet path.

Top module: `route_hop_checker`

## Requirements
- R1: The input port code is 0 local, 1 north, 2 east, 3 south, 4 west, with north at lower Y. A header on port 4 came from (x-1,y) moving east, port 2 from (x+1,y) moving west, port 1 from (x,y-1) moving south, and port 3 from (x,y+1) moving north.
- R2: The expected upstream choice is east if the upstream X is below the destination X, and west if it is above. Only when the X values are equal is Y compared: south if the upstream Y is below the destination Y, north if it is above. When both are equal the expected choice is local ejection. A hop that matches the expected choice gets class code 2'b00 (correct).
- R3: A hop that differs from the expected choice gets class code 2'b10 (error) when the router the expected choice leads to is available.
- R4: A hop that differs from the expected choice gets class code 2'b01 (bypass) when that router is unavailable. The availability map bit index is y*MESH_X+x, and 1 means available.
- R5: A header on port 0, or on an undefined port code 5 to 7, gets class 2'b00.
- R6: A hop whose upstream router already held the destination, or whose upstream position lies outside the mesh, gets class 2'b10.
- R7: The class output and the valid pulse appear on the clock edge after the one that samples the header strobe. The class holds its value while no strobe arrives, and class code 2'b11 never appears.
- R8: The sticky error flag sets on every header classed 2'b10 and stays set until the clear input is sampled high. A new error in the same cycle as a clear leaves the flag set.
- R9: After reset the class is 2'b00 and the valid and sticky outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| in_port | input | 3 | Arrival port code |
| cur_x | input | XW | Local router X |
| cur_y | input | YW | Local router Y |
| dst | input | XW+YW | Destination packed {X,Y} |
| avail | input | MESH_X*MESH_Y | Node availability map |
| clr_err | input | 1 | Clears the sticky error flag |
| cls_o | output | 2 | Hop class code |
| vld_o | output | 1 | Class updated this cycle |
| err_o | output | 1 | Sticky routing-error flag |

## Verification
The properties assume the availability map, the coordinates and the port code are stable and meaningful in the cycle the header strobe is high. They also assume the destination lies inside the mesh, so the expected hop never points off the mesh edge. The directed stimulus places every header at an in-mesh local router with an in-mesh destination. It changes the availability map only between headers, so each header is judged against one known map.

// File: rtl/route_hop_checker.sv
module route_hop_checker #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  localparam int NODES = MESH_X * MESH_Y
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  input  logic [2:0]       in_port,
  input  logic [XW-1:0]    cur_x,
  input  logic [YW-1:0]    cur_y,
  input  logic [XW+YW-1:0] dst,
  input  logic [NODES-1:0] avail,
  input  logic             clr_err,
  output logic [1:0]       cls_o,
  output logic             vld_o,
  output logic             err_o
);
  localparam logic [2:0] P_LOC = 3'd0, P_N = 3'd1, P_E = 3'd2, P_S = 3'd3, P_W = 3'd4;
  localparam logic [1:0] C_OK = 2'b00, C_BYP = 2'b01, C_ERR = 2'b10;

  int px, py, tx, ty, dx, dy;
  logic [2:0] act, expd;
  logic prev_in, tgt_av;
  logic [1:0] cls_d;

  assign dx = int'(dst[XW+YW-1:YW]);
  assign dy = int'(dst[YW-1:0]);

  always_comb begin
    px = int'(cur_x);
    py = int'(cur_y);
    act = P_LOC;
    case (in_port)
      P_W: begin px = int'(cur_x) - 1; act = P_E; end
      P_E: begin px = int'(cur_x) + 1; act = P_W; end
      P_N: begin py = int'(cur_y) - 1; act = P_S; end
      P_S: begin py = int'(cur_y) + 1; act = P_N; end
      default: act = P_LOC;
    endcase
  end

  assign prev_in = (px >= 0) && (px < MESH_X) && (py >= 0) && (py < MESH_Y);

  always_comb begin
    tx = px;
    ty = py;
    if (px < dx) begin expd = P_E; tx = px + 1; end
    else if (px > dx) begin expd = P_W; tx = px - 1; end
    else if (py < dy) begin expd = P_S; ty = py + 1; end
    else if (py > dy) begin expd = P_N; ty = py - 1; end
    else expd = P_LOC;
  end

  always_comb begin
    tgt_av = 1'b0;
    for (int i = 0; i < NODES; i++)
      if (tx == (i % MESH_X) && ty == (i / MESH_X)) tgt_av = avail[i];
  end

  always_comb begin
    if (act == P_LOC) cls_d = C_OK;
    else if (!prev_in) cls_d = C_ERR;
    else if (expd == act) cls_d = C_OK;
    else if (expd == P_LOC) cls_d = C_ERR;
    else if (!tgt_av) cls_d = C_BYP;
    else cls_d = C_ERR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_o <= C_OK;
      vld_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      vld_o <= hdr_valid;
      if (hdr_valid) cls_o <= cls_d;
      if (hdr_valid && cls_d == C_ERR) err_o <= 1'b1;
      else if (clr_err) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/route_hop_checker_sva.sv
module route_hop_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_valid,
  input logic [2:0] in_port,
  input logic       clr_err,
  input logic [1:0] cls_o,
  input logic       vld_o,
  input logic       err_o
);
  // R7
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid |=> vld_o);
  // R7
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !hdr_valid |=> !vld_o);
  // R7
  cls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !hdr_valid |=> $stable(cls_o));
  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) cls_o != 2'b11);
  // R5
  local_ok_chk: assert property (@(posedge clk) disable iff (!rst_n) (hdr_valid && in_port == 3'd0) |=> cls_o == 2'b00);
  // R8
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_o) |-> (vld_o && cls_o == 2'b10));
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (err_o && !clr_err) |=> err_o);
  // R8
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr_err && !hdr_valid) |=> !err_o);
endmodule

bind route_hop_checker route_hop_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .in_port(in_port),
  .clr_err(clr_err), .cls_o(cls_o), .vld_o(vld_o), .err_o(err_o)
);

// File: tb/route_hop_checker_bench.sv
module route_hop_checker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [2:0] in_port = 3'd0;
  logic [1:0] cur_x = '0;
  logic [1:0] cur_y = '0;
  logic [3:0] dst = '0;
  logic [15:0] avail = '1;
  logic clr_err = 1'b0;
  logic [1:0] cls_o;
  logic vld_o, err_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  route_hop_checker u_route_hop_checker (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .in_port(in_port),
    .cur_x(cur_x), .cur_y(cur_y), .dst(dst), .avail(avail), .clr_err(clr_err),
    .cls_o(cls_o), .vld_o(vld_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hop(input string req, input int cx, input int cy, input int port,
                     input int dx, input int dy, input int exp_cls);
    @(negedge clk);
    cur_x = 2'(cx); cur_y = 2'(cy); in_port = 3'(port);
    dst = {2'(dx), 2'(dy)}; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(req, int'(cls_o), exp_cls);
    check({req, " valid"}, int'(vld_o), 1);
  endtask

  task automatic t_reset();
    check("R9 class", int'(cls_o), 0);
    check("R9 valid", int'(vld_o), 0);
    check("R9 sticky", int'(err_o), 0);
  endtask

  task automatic t_correct();
    hop("R1 east hop", 2, 1, 4, 3, 2, 0);
    hop("R1 west hop", 1, 2, 2, 0, 0, 0);
    hop("R2 south hop", 2, 2, 1, 2, 3, 0);
    hop("R2 north hop", 3, 1, 3, 3, 0, 0);
    check("R8 no error yet", int'(err_o), 0);
  endtask

  task automatic t_error_bypass();
    avail = '1;
    hop("R3 X skipped", 2, 2, 1, 3, 3, 2);
    check("R8 sticky set", int'(err_o), 1);
    avail[7] = 1'b0;
    hop("R4 bypass X", 2, 2, 1, 3, 3, 1);
    avail = '1;
    hop("R3 Y wrong", 1, 2, 4, 0, 3, 2);
    avail[12] = 1'b0;
    hop("R4 bypass Y", 1, 2, 4, 0, 3, 1);
    avail = '1;
    @(negedge clk);
    check("R7 class held", int'(cls_o), 1);
    check("R7 no pulse", int'(vld_o), 0);
  endtask

  task automatic t_local_and_edges();
    hop("R5 local port", 3, 3, 0, 0, 0, 0);
    hop("R5 undefined port", 1, 1, 6, 3, 3, 0);
    hop("R6 passed destination", 1, 1, 4, 0, 1, 2);
    hop("R6 off mesh", 0, 0, 4, 2, 2, 2);
  endtask

  task automatic t_sticky();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    check("R8 cleared", int'(err_o), 0);
    hop("R8 correct keeps clear", 2, 1, 4, 3, 2, 0);
    check("R8 still clear", int'(err_o), 0);
    @(negedge clk);
    cur_x = 2'd2; cur_y = 2'd2; in_port = 3'd1; dst = {2'd3, 2'd3};
    hdr_valid = 1'b1; clr_err = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0; clr_err = 1'b0;
    check("R8 set beats clear", int'(err_o), 1);
    hop("R8 held after correct", 2, 1, 4, 3, 2, 0);
    check("R8 held", int'(err_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_correct();
    t_error_bypass();
    t_local_and_edges();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule